// File: doc/BRIEF.md
# Maskable Interrupt Register Bank

This block collects interrupt events for a network controller and turns them into one interrupt line. Up to thirty event sources each have a status bit that latches a single-cycle pulse and a mask bit that says whether that source may drive the interrupt. Software reads the status register to learn which events happened; the read also clears it. Software reads the mask register to see which sources are disabled.

Mask bits are never written directly. A write-one-to-enable register clears chosen mask bits, and a write-one-to-disable register sets them. The mask address is read-only for the mask itself. A write to it is reused as a test port that loads the status bits directly, whatever the mask holds, so interrupt handling software can be exercised without real traffic.

Every bus access is decoded into one access kind: `ACC_IDLE`, `ACC_SET_EN`, `ACC_SET_DIS`, `ACC_FORCE`, `ACC_RD_STAT`, `ACC_RD_MASK` or `ACC_RD_ZERO`. The access kind is computed fresh each cycle from the strobes and the address and does not carry state. The address offsets are status 0x00, enable 0x04, disable 0x08 and mask 0x0C. A write takes effect at the clock edge that samples it. Read data is registered and appears one cycle after the read strobe. It then holds until the next read.

Top module: `irq_regbank`

## Requirements
- R1: After reset the mask register (offset 0x0C) reads 0x3FFC3FFF, the status register (offset 0x00) reads 0 and `irq` is low.
- R2: Writing the enable register (offset 0x04) clears every mask bit written as 1 and leaves bits written as 0 unchanged.
- R3: Writing the disable register (offset 0x08) sets every mask bit written as 1 and leaves bits written as 0 unchanged.
- R4: A write to the mask offset 0x0C leaves the mask unchanged. It loads the written value into the implemented status bits, which can set them or clear them.
- R5: A 1 written into a status bit through the mask offset raises `irq` when that source is enabled. It does not raise `irq` when that source is masked.
- R6: The implemented bits are 0 to 13 and 18 to 29. Bits 14 to 17, 30 and 31 always read 0 in both status and mask, and writes to them are ignored.
- R7: A read of the status register returns its contents and clears every status bit. This includes bit 27, the receive low-power indication change.
- R8: An event pulse that arrives in the same cycle as a status read is not lost. The read returns the older contents, and the bit of the new event is set afterwards.
- R9: An event pulse sets its status bit even when the source is masked. Enabling that source later raises `irq`.
- R10: `irq` is a register output. After every clock edge it equals the OR over all bits of (status AND NOT mask). It falls when the pending bits are cleared or when their sources are disabled.
- R11: The write-only offsets 0x04 and 0x08, and any unmapped offset, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W | Registered read data |
| evt_pulse | input | DATA_W | Single-cycle event pulses, one per source bit |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions take for granted that the write strobe and the read strobe are never high in the same cycle. If both were high, the decoder would let the write win and the read would be dropped, and the status-clear property would no longer apply. They also take for granted that event pulses last one cycle. The directed stimulus drives one bus strobe per cycle and holds each event vector for a single cycle. Events are combined with a status read only in the scenario built to test that case.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;

    localparam int          REG_DW      = 32;
    localparam logic [31:0] SRC_IMPL    = 32'h3FFC_3FFF;
    localparam logic [7:0]  OFS_STATUS  = 8'h00;
    localparam logic [7:0]  OFS_ENABLE  = 8'h04;
    localparam logic [7:0]  OFS_DISABLE = 8'h08;
    localparam logic [7:0]  OFS_MASK    = 8'h0C;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_SET_EN,
        ACC_SET_DIS,
        ACC_FORCE,
        ACC_RD_STAT,
        ACC_RD_MASK,
        ACC_RD_ZERO
    } acc_e;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output acc_e              acc
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DISABLE);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

    // The write strobe wins if both strobes are high.
    always_comb begin
        acc = ACC_IDLE;
        if (bus_wr) begin
            if (bus_addr == A_EN)        acc = ACC_SET_EN;
            else if (bus_addr == A_DIS)  acc = ACC_SET_DIS;
            else if (bus_addr == A_MASK) acc = ACC_FORCE;
            else                         acc = ACC_IDLE;
        end else if (bus_rd) begin
            if (bus_addr == A_STAT)      acc = ACC_RD_STAT;
            else if (bus_addr == A_MASK) acc = ACC_RD_MASK;
            else                         acc = ACC_RD_ZERO;
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_regbank_pkg::*;
#(
    parameter int          DATA_W = REG_DW,
    parameter logic [31:0] IMPL   = SRC_IMPL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              acc,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] mask_d
);

    localparam logic [DATA_W-1:0] IMPL_W = IMPL[DATA_W-1:0];

    logic [DATA_W-1:0] en_bits;
    logic [DATA_W-1:0] dis_bits;

    always_comb begin
        en_bits  = '0;
        dis_bits = '0;
        unique case (acc)
            ACC_SET_EN:  en_bits  = wdata & IMPL_W;
            ACC_SET_DIS: dis_bits = wdata & IMPL_W;
            default: ;
        endcase
        // Disable is applied after enable, so it takes precedence on a conflict.
        mask_d = (mask_q & ~en_bits) | dis_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= IMPL_W;
        else        mask_q <= mask_d;
    end

    AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_SET_EN) |=> ((mask_q & $past(wdata & IMPL_W)) == '0)); // R2
    AST_DIS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_SET_DIS) |=> ((mask_q & $past(wdata & IMPL_W)) == $past(wdata & IMPL_W))); // R3
    AST_FORCE_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_FORCE) |=> $stable(mask_q)); // R4
    AST_MASK_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_q & ~IMPL_W) == '0)); // R6

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_regbank_pkg::*;
#(
    parameter int          DATA_W = REG_DW,
    parameter logic [31:0] IMPL   = SRC_IMPL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              acc,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] evt,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] status_d
);

    localparam logic [DATA_W-1:0] IMPL_W = IMPL[DATA_W-1:0];

    logic [DATA_W-1:0] base;

    always_comb begin
        unique case (acc)
            ACC_FORCE:   base = wdata;
            ACC_RD_STAT: base = '0;
            default:     base = status_q;
        endcase
        // A new event always lands on top of a clear or a forced load.
        status_d = (base | evt) & IMPL_W;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & IMPL_W) != '0) |=> ((status_q & $past(evt & IMPL_W)) == $past(evt & IMPL_W))); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_RD_STAT && evt == '0) |=> (status_q == '0)); // R7
    AST_STAT_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~IMPL_W) == '0)); // R6

endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
    import irq_regbank_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter int          DATA_W = REG_DW,
    parameter logic [31:0] IMPL   = SRC_IMPL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] evt_pulse,
    output logic              irq
);

    acc_e              acc;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] mask_d;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] status_d;
    logic [DATA_W-1:0] rdata_q;
    logic              irq_q;

    irq_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .acc      (acc)
    );

    irq_mask_reg #(.DATA_W(DATA_W), .IMPL(IMPL)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc),
        .wdata  (bus_wdata),
        .mask_q (mask_q),
        .mask_d (mask_d)
    );

    irq_status_reg #(.DATA_W(DATA_W), .IMPL(IMPL)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .wdata    (bus_wdata),
        .evt      (evt_pulse),
        .status_q (status_q),
        .status_d (status_d)
    );

    // The interrupt is registered from next-state values, so it moves with the registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_d & ~mask_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            unique case (acc)
                ACC_RD_STAT: rdata_q <= status_q;
                ACC_RD_MASK: rdata_q <= mask_q;
                ACC_RD_ZERO: rdata_q <= '0;
                default:     rdata_q <= rdata_q;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
    assign irq       = irq_q;

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q == |(status_q & ~mask_q))); // R10
    AST_RDATA_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdata_q & ~IMPL[DATA_W-1:0]) == '0)); // R6
    AST_MASK_READ_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_RD_MASK) |=> (rdata_q == $past(mask_q))); // R1

endmodule

// File: tb/test_irq_regbank.sv
module test_irq_regbank;

    localparam int          AW   = 8;
    localparam int          DW   = 32;
    localparam logic [31:0] IMPL = 32'h3FFC_3FFF;
    localparam logic [7:0]  A_ST = 8'h00;
    localparam logic [7:0]  A_EN = 8'h04;
    localparam logic [7:0]  A_DI = 8'h08;
    localparam logic [7:0]  A_MK = 8'h0C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic [DW-1:0] evt_pulse = '0;
    logic          irq;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    irq_regbank i_irq_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .evt_pulse (evt_pulse),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] ev, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; evt_pulse = ev;
        @(negedge clk);
        bus_rd = 1'b0; evt_pulse = '0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] ev);
        @(negedge clk);
        evt_pulse = ev;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd(A_MK, '0, d); check("R1 mask", d, IMPL);
        rd(A_ST, '0, d); check("R1 status", d, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(A_EN, 32'h0000_0005);
        rd(A_MK, '0, d); check("R2 enable", d, IMPL & ~32'h5);
        wr(A_EN, 32'h0);
        rd(A_MK, '0, d); check("R2 zero no-op", d, IMPL & ~32'h5);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        wr(A_DI, 32'h0000_0001);
        rd(A_MK, '0, d); check("R3 disable", d, IMPL & ~32'h4);
    endtask

    task automatic t_force();
        logic [31:0] d;
        wr(A_MK, 32'h0000_0004);
        check("R5 irq enabled src", {31'b0, irq}, 32'h1);
        rd(A_MK, '0, d); check("R4 mask kept", d, IMPL & ~32'h4);
        rd(A_ST, '0, d); check("R4 status loaded", d, 32'h4);
        check("R10 irq falls after clear", {31'b0, irq}, 32'h0);
        wr(A_MK, 32'h0000_0008);
        check("R5 masked src no irq", {31'b0, irq}, 32'h0);
        wr(A_MK, 32'h0);
        rd(A_ST, '0, d); check("R4 force clears", d, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(A_MK, 32'hFFFF_FFFF);
        check("R5 irq after force all", {31'b0, irq}, 32'h1);
        rd(A_ST, '0, d); check("R6 status reserved", d, IMPL);
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_MK, '0, d); check("R6 enable all", d, 32'h0);
        wr(A_DI, 32'hFFFF_FFFF);
        rd(A_MK, '0, d); check("R6 mask reserved", d, IMPL);
    endtask

    task automatic t_read_clear();
        logic [31:0] d;
        pulse(32'h0800_0000);
        rd(A_ST, '0, d); check("R7 lpi change read", d, 32'h0800_0000);
        rd(A_ST, '0, d); check("R7 cleared on read", d, 32'h0);
    endtask

    task automatic t_read_race();
        logic [31:0] d;
        pulse(32'h1);
        rd(A_ST, 32'h2, d); check("R8 read returns old", d, 32'h1);
        rd(A_ST, '0, d); check("R8 new event kept", d, 32'h2);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        pulse(32'h0010_0000);
        check("R9 masked no irq", {31'b0, irq}, 32'h0);
        wr(A_EN, 32'h0010_0000);
        check("R9 irq on enable", {31'b0, irq}, 32'h1);
        wr(A_DI, 32'h0010_0000);
        check("R10 irq falls on disable", {31'b0, irq}, 32'h0);
        rd(A_ST, '0, d); check("R9 still pending", d, 32'h0010_0000);
    endtask

    task automatic t_wo_regs();
        logic [31:0] d;
        rd(A_MK, '0, d);
        rd(A_EN, '0, d); check("R11 enable reads 0", d, 32'h0);
        rd(A_MK, '0, d);
        rd(A_DI, '0, d); check("R11 disable reads 0", d, 32'h0);
        rd(A_MK, '0, d);
        rd(8'h40, '0, d); check("R11 unmapped reads 0", d, 32'h0);
    endtask

    initial begin
        #500000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_disable();
        t_force();
        t_reserved();
        t_read_clear();
        t_read_race();
        t_pending();
        t_wo_regs();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule